// File: doc/BRIEF.md
# Condition and Flag Unit

This block is combinational logic for the execute stage of a 32-bit processor. It takes the two operands and the result of an addition or a subtraction and works out the four status flags: negative, zero, carry and overflow. The adder is outside the block, and so are the shifter carry and the flags of logical operations.

Alongside the flags, the block decides whether the current instruction may execute. It compares a 4-bit condition field against the flag register as it is now, and drives a single enable bit. The two halves are independent. The flags the block produces here do not feed the enable in the same cycle; writing them back to the flag register is the job of the surrounding pipeline.

All pins are plain control and status signals. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure. Every output is a pure function of the present inputs.

Top module: `cond_flag_unit`

## Requirements
- R1: The new flags are packed as {N, Z, C, V} in `flags_out[3:0]`, and N equals bit 31 of `res_in`.
- R2: Z (`flags_out[2]`) is 1 exactly when all 32 bits of `res_in` are zero.
- R3: With `sub_sel`=0 (addition), C (`flags_out[1]`) is 1 when the sum of the top bits of `op_a` and `op_b`, taken as integers, exceeds the top bit of `res_in`.
- R4: With `sub_sel`=1 (subtraction), C is 1 exactly when `op_a` is greater than or equal to `op_b` as unsigned numbers. C is then a not-borrow.
- R5: With `sub_sel`=0, V (`flags_out[0]`) is 1 when `op_a` and `op_b` have the same sign bit and the sign bit of `res_in` differs from both.
- R6: With `sub_sel`=1, V is 1 when the sign bits of `op_a` and `op_b` differ and the sign bit of `res_in` differs from that of `op_a`.
- R7: The current flags arrive as `flags_in` = {N, Z, C, V}. Codes 0 to 7 each test a single flag: 0 Z set, 1 Z clear, 2 C set, 3 C clear, 4 N set, 5 N clear, 6 V set, 7 V clear.
- R8: Code 8 enables when C is set and Z is clear. Code 9 enables when C is clear or Z is set.
- R9: Code 10 enables when N equals V. Code 11 enables when N differs from V.
- R10: Code 12 enables when Z is clear and N equals V. Code 13 enables when Z is set or N differs from V.
- R11: Code 14 always drives `exec_en` high. Code 15 always drives it low.
- R12: `flags_out` depends on neither `flags_in` nor `cond_code`. `exec_en` depends on neither the operands, the result nor `sub_sel`. Both settle in the same cycle as their inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand of the arithmetic operation |
| op_b | input | 32 | Second operand of the arithmetic operation |
| res_in | input | 32 | Result produced by the external adder |
| sub_sel | input | 1 | 0 = addition, 1 = subtraction (op_a - op_b) |
| flags_in | input | 4 | Current flag register {N, Z, C, V} |
| cond_code | input | 4 | Condition field of the instruction |
| flags_out | output | 4 | Newly computed flags {N, Z, C, V} |
| exec_en | output | 1 | 1 when the instruction is allowed to execute |

## Verification
The block holds no state, so a fault cannot hide and come out later. A wrong carry or overflow term shows on `flags_out` in the same cycle as the operands that trigger it. A miswired condition decode shows on `exec_en` as soon as the code and the flag pattern select it. The bench therefore drives all sixteen codes against all sixteen flag patterns. It then pushes the sign and carry boundary values through both operations, where an inverted not-borrow or a swapped overflow operand is visible at once.

// File: rtl/cond_flag_pkg.sv
package cond_flag_pkg;

  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
    logic ovf;
  } flag_set_t;

  typedef enum logic [3:0] {
    CC_ZS  = 4'd0,
    CC_ZC  = 4'd1,
    CC_CS  = 4'd2,
    CC_CC  = 4'd3,
    CC_NS  = 4'd4,
    CC_NC  = 4'd5,
    CC_VS  = 4'd6,
    CC_VC  = 4'd7,
    CC_UGT = 4'd8,
    CC_ULE = 4'd9,
    CC_SGE = 4'd10,
    CC_SLT = 4'd11,
    CC_SGT = 4'd12,
    CC_SLE = 4'd13,
    CC_ALW = 4'd14,
    CC_NEV = 4'd15
  } cond_sel_t;

endpackage

// File: rtl/cond_flag_gen.sv
module cond_flag_gen
  import cond_flag_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] r_i,
  input  logic         sub_i,
  output flag_set_t    f_o
);
  localparam int MSB = W - 1;

  logic sa, sb, sr;
  logic [1:0] top_sum;
  logic c_add, c_sub, v_add, v_sub;

  always_comb begin
    sa = a_i[MSB];
    sb = b_i[MSB];
    sr = r_i[MSB];
    top_sum = {1'b0, sa} + {1'b0, sb};
    c_add = top_sum > {1'b0, sr};
    c_sub = a_i >= b_i;
    v_add = ~(sa ^ sb) & (sa ^ sr) & (sb ^ sr);
    v_sub = (sa ^ sb) & (sa ^ sr);
    f_o.neg   = sr;
    f_o.zero  = ~|r_i;
    f_o.carry = sub_i ? c_sub : c_add;
    f_o.ovf   = sub_i ? v_sub : v_add;
  end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import cond_flag_pkg::*;
(
  input  flag_set_t  cur_i,
  input  logic [3:0] code_i,
  output logic       pass_o
);
  logic sign_ok;

  always_comb begin
    sign_ok = (cur_i.neg == cur_i.ovf);
    unique case (cond_sel_t'(code_i))
      CC_ZS:  pass_o = cur_i.zero;
      CC_ZC:  pass_o = ~cur_i.zero;
      CC_CS:  pass_o = cur_i.carry;
      CC_CC:  pass_o = ~cur_i.carry;
      CC_NS:  pass_o = cur_i.neg;
      CC_NC:  pass_o = ~cur_i.neg;
      CC_VS:  pass_o = cur_i.ovf;
      CC_VC:  pass_o = ~cur_i.ovf;
      CC_UGT: pass_o = cur_i.carry & ~cur_i.zero;
      CC_ULE: pass_o = ~cur_i.carry | cur_i.zero;
      CC_SGE: pass_o = sign_ok;
      CC_SLT: pass_o = ~sign_ok;
      CC_SGT: pass_o = ~cur_i.zero & sign_ok;
      CC_SLE: pass_o = cur_i.zero | ~sign_ok;
      CC_ALW: pass_o = 1'b1;
      default: pass_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
  import cond_flag_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] res_in,
  input  logic         sub_sel,
  input  logic [3:0]   flags_in,
  input  logic [3:0]   cond_code,
  output logic [3:0]   flags_out,
  output logic         exec_en
);
  flag_set_t new_f;
  flag_set_t cur_f;

  assign cur_f = flag_set_t'(flags_in);

  cond_flag_gen #(.W(W)) u_gen (
    .a_i  (op_a),
    .b_i  (op_b),
    .r_i  (res_in),
    .sub_i(sub_sel),
    .f_o  (new_f)
  );

  cond_eval u_eval (
    .cur_i (cur_f),
    .code_i(cond_code),
    .pass_o(exec_en)
  );

  assign flags_out = new_f;
endmodule

// File: rtl/cond_flag_unit_chk.sv
module cond_flag_unit_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [W-1:0] res_in,
  input logic         sub_sel,
  input logic [3:0]   flags_in,
  input logic [3:0]   cond_code,
  input logic [3:0]   flags_out,
  input logic         exec_en
);
  always_comb begin
    // R1
    neg_bit_chk: assert (flags_out[3] == res_in[W-1]);
    // R2
    zero_res_chk: assert (!(res_in == '0) || flags_out[2]);
    // R4
    equal_sub_carry_chk: assert (!(sub_sel && op_a == op_b) || flags_out[1]);
    // R5
    same_sign_add_chk: assert (!(!sub_sel && op_a[W-1] == res_in[W-1] && op_b[W-1] == res_in[W-1]) || !flags_out[0]);
    // R6
    same_sign_sub_chk: assert (!(sub_sel && op_a[W-1] == op_b[W-1]) || !flags_out[0]);
    // R11
    always_code_chk: assert (!(cond_code == 4'd14) || exec_en);
    // R11
    never_code_chk: assert (!(cond_code == 4'd15) || !exec_en);
    // R9
    ge_lt_chk: assert (!(cond_code == 4'd10 && flags_in[3] != flags_in[0]) || !exec_en);
  end
endmodule

bind cond_flag_unit cond_flag_unit_chk #(.W(W)) u_chk (
  .op_a     (op_a),
  .op_b     (op_b),
  .res_in   (res_in),
  .sub_sel  (sub_sel),
  .flags_in (flags_in),
  .cond_code(cond_code),
  .flags_out(flags_out),
  .exec_en  (exec_en)
);

// File: tb/cond_flag_unit_test.sv
module cond_flag_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] op_a, op_b, res_in;
  logic        sub_sel;
  logic [3:0]  flags_in, cond_code, flags_out;
  logic        exec_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  cond_flag_unit uut (
    .op_a(op_a), .op_b(op_b), .res_in(res_in), .sub_sel(sub_sel),
    .flags_in(flags_in), .cond_code(cond_code),
    .flags_out(flags_out), .exec_en(exec_en)
  );

  function automatic logic [3:0] exp_flags(logic [31:0] a, logic [31:0] b,
                                           logic [31:0] r, logic s);
    logic n, z, c, v;
    n = r[31];
    z = (r == 32'd0);
    if (s) begin
      c = (a >= b);
      v = (a[31] != b[31]) && (r[31] != a[31]);
    end else begin
      c = (int'(a[31]) + int'(b[31])) > int'(r[31]);
      v = (a[31] == b[31]) && (r[31] != a[31]);
    end
    return {n, z, c, v};
  endfunction

  function automatic logic exp_exec(logic [3:0] code, logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (code)
      4'd0: return z;
      4'd1: return !z;
      4'd2: return c;
      4'd3: return !c;
      4'd4: return n;
      4'd5: return !n;
      4'd6: return v;
      4'd7: return !v;
      4'd8: return c && !z;
      4'd9: return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_cond(logic [3:0] code);
    if (code < 4'd8) return "R7";
    if (code < 4'd10) return "R8";
    if (code < 4'd12) return "R9";
    if (code < 4'd14) return "R10";
    return "R11";
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply_arith(logic [31:0] a, logic [31:0] b, logic s);
    logic [3:0] e;
    @(negedge clk);
    op_a = a; op_b = b; sub_sel = s;
    res_in = s ? a - b : a + b;
    #2;
    e = exp_flags(a, b, res_in, s);
    check("R1", {31'd0, flags_out[3]}, {31'd0, e[3]});
    check("R2", {31'd0, flags_out[2]}, {31'd0, e[2]});
    check(s ? "R4" : "R3", {31'd0, flags_out[1]}, {31'd0, e[1]});
    check(s ? "R6" : "R5", {31'd0, flags_out[0]}, {31'd0, e[0]});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] ref_f;
    logic       ref_e;
    logic [31:0] ra, rb, rr;
    void'($urandom(32'd20240611));
    op_a = 0; op_b = 0; res_in = 0; sub_sel = 0; flags_in = 0; cond_code = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: zero result addition gives only Z; code 0 with no flags blocks
    check("R2", {28'd0, flags_out}, 32'h4);
    check("R7", {31'd0, exec_en}, 32'd0);

    // exhaustive condition decode
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        @(negedge clk);
        cond_code = 4'(c); flags_in = 4'(f);
        #2;
        check(tag_cond(4'(c)), {31'd0, exec_en}, {31'd0, exp_exec(4'(c), 4'(f))});
      end
    end

    // directed arithmetic corners
    apply_arith(32'h7FFF_FFFF, 32'h0000_0001, 1'b0); // signed overflow
    apply_arith(32'hFFFF_FFFF, 32'h0000_0001, 1'b0); // carry, zero
    apply_arith(32'h8000_0000, 32'h8000_0000, 1'b0); // carry and overflow
    apply_arith(32'h8000_0000, 32'h0000_0001, 1'b1); // sub overflow
    apply_arith(32'h1234_5678, 32'h1234_5678, 1'b1); // equal: not-borrow set, zero
    apply_arith(32'h0000_0000, 32'h0000_0001, 1'b1); // borrow
    apply_arith(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1); // sub overflow other sign
    apply_arith(32'hFFFF_FFFF, 32'h0000_0000, 1'b1);

    // random arithmetic, consistent results
    for (int i = 0; i < 3000; i++) begin
      ra = $urandom; rb = $urandom;
      if (i % 7 == 0) rb = ra;
      apply_arith(ra, rb, 1'(i % 2));
    end

    // random arbitrary result values: flag formulas in top-bit terms
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      ra = $urandom; rb = $urandom; rr = (i % 9 == 0) ? 32'd0 : $urandom;
      op_a = ra; op_b = rb; res_in = rr; sub_sel = 1'($urandom);
      flags_in = 4'($urandom); cond_code = 4'($urandom);
      #2;
      ref_f = exp_flags(ra, rb, rr, sub_sel);
      ref_e = exp_exec(cond_code, flags_in);
      check(sub_sel ? "R4/R6" : "R3/R5", {28'd0, flags_out}, {28'd0, ref_f});
      check(tag_cond(cond_code), {31'd0, exec_en}, {31'd0, ref_e});
    end

    // R12: flags_out ignores flags_in/cond_code; exec_en ignores arithmetic inputs
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      op_a = $urandom; op_b = $urandom; sub_sel = 1'($urandom);
      res_in = sub_sel ? op_a - op_b : op_a + op_b;
      flags_in = 4'($urandom); cond_code = 4'($urandom);
      #2;
      ref_f = exp_flags(op_a, op_b, res_in, sub_sel);
      ref_e = exp_exec(cond_code, flags_in);
      flags_in = ~flags_in; cond_code = cond_code ^ 4'd5;
      #2;
      check("R12", {28'd0, flags_out}, {28'd0, ref_f});
      flags_in = ~flags_in; cond_code = cond_code ^ 4'd5;
      op_a = $urandom; op_b = $urandom; res_in = $urandom; sub_sel = ~sub_sel;
      #2;
      check("R12", {31'd0, exec_en}, {31'd0, ref_e});
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule